// File: doc/BRIEF.md
# Pointer Address Generator for a Signal-Processing Datapath

This block sits beside a fixed-point arithmetic pipeline and supplies the memory address for each operand fetch. It holds four independent pointer channels. When an access strobe names a channel, the block emits that channel's current pointer as the address. In the same cycle it computes and stores the pointer for the following access. The arithmetic units therefore spend no instruction slots on address arithmetic.

Each channel has five registers: a pointer, a signed step, a ring start, a ring span and a stepping mode. A sixth register, a size exponent, is used only by the reversed-carry mode. The modes are:
- hold (plain register-indirect),
- linear post-increment,
- ring post-increment, which serves coefficient tables that restart for every output sample and input delay lines used as FIFOs,
- reversed-carry post-increment, which walks FFT data in bit-reversed order.

Registers are loaded through one narrow write port with a channel select and a field code. The address output carries a valid flag but no ready. The attached memory port must take every address in the cycle it appears, so back-pressure has to be applied upstream by withholding the strobe.

Top module: `agu_top`

## Requirements
- R1: After reset `addr_vld` is 0 and `addr_out` is 0. Every channel then has pointer 0, step 0, ring start 0, span 0, hold mode and size exponent 0.
- R2: In hold mode (mode code 0), an access returns the pointer and leaves it unchanged.
- R3: In linear mode (mode code 1), an access returns the pointer, then replaces it with pointer plus step modulo 2^AW. The step is read as two's complement.
- R4: In ring mode (mode code 2) with a non-negative step, let s be pointer plus step. If s is at or beyond start plus span, the new pointer is s minus span; otherwise it is s.
- R5: In ring mode with a negative step, if s is below the ring start, the new pointer is s plus span; otherwise it is s.
- R6: In reversed-carry mode (mode code 3), let k be the size exponent clamped to the range 1..10 (0 counts as 1, above 10 counts as 10). The low k bits of the pointer are added to the low k bits of the step with the carry running from bit k-1 down toward bit 0, and the carry out of bit 0 is dropped. Pointer bits k and above are kept.
- R7: A strobe changes only the pointer of the channel named by `acc_sel`. All other channels keep their pointers.
- R8: `addr_out` and `addr_vld` are registered. The address of a strobe in cycle t appears with `addr_vld` = 1 after the edge that ends cycle t. With no strobe, `addr_vld` is 0 and `addr_out` keeps its last value.
- R9: A pointer write is seen by a strobe in the next cycle. If a pointer write and a strobe hit the same channel in the same cycle, the strobe returns the old pointer and the written value replaces the stepped value.
- R10: `wr_field` codes are: 0 pointer, 1 step, 2 ring start, 3 span, 4 mode (low 2 bits of `wr_data`), 5 size exponent (low 4 bits). Codes 6 and 7 change nothing. A strobe in the same cycle as a write to a non-pointer field uses the old field value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | CSW | Channel addressed by the write |
| wr_field | input | 3 | Field code of the write |
| wr_data | input | AW | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_sel | input | CSW | Channel used by the access |
| addr_out | output | AW | Registered address |
| addr_vld | output | 1 | Address valid, one cycle after the strobe |

## Verification
The bench targets the wrap boundaries of ring mode.
- A sum landing exactly on start plus span must wrap; a design using a strict compare would emit an address one past the buffer.
- Negative steps must wrap just below the start; a design that handles only the upper edge walks out of the buffer downward.
- In reversed-carry mode the bench clamps the size exponent at 0 and above 10 and walks a full 8-point permutation. A normal-carry adder would emit linear order, and a missing clamp would corrupt the upper pointer bits.
- The bench also hits a pointer write and a strobe on the same channel in the same cycle, and a write with an unused field code. Wrong priority or a loose decode would show up as a wrong next address.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_HOLD     = 2'd0,
    AM_LINEAR   = 2'd1,
    AM_RING     = 2'd2,
    AM_REVCARRY = 2'd3
  } amode_t;

  localparam logic [2:0] FLD_PTR  = 3'd0;
  localparam logic [2:0] FLD_STEP = 3'd1;
  localparam logic [2:0] FLD_BASE = 3'd2;
  localparam logic [2:0] FLD_LEN  = 3'd3;
  localparam logic [2:0] FLD_MODE = 3'd4;
  localparam logic [2:0] FLD_SIZE = 3'd5;
endpackage

// File: rtl/agu_ring_step.sv
module agu_ring_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum_e;
  logic signed [EW-1:0] base_e;
  logic signed [EW-1:0] len_e;
  logic signed [EW-1:0] lim_e;
  logic signed [EW-1:0] res_e;
  logic                 neg;

  always_comb begin
    neg    = step[AW-1];
    base_e = $signed({2'b00, base});
    len_e  = $signed({2'b00, len});
    lim_e  = base_e + len_e;
    sum_e  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    res_e  = sum_e;
    if (neg) begin
      if (sum_e < base_e) res_e = sum_e + len_e;
    end else begin
      if (sum_e >= lim_e) res_e = sum_e - len_e;
    end
    nxt = res_e[AW-1:0];
  end
endmodule

// File: rtl/agu_revcarry.sv
module agu_revcarry #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int SZW    = 4
) (
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  step,
  input  logic [SZW-1:0] k,
  output logic [AW-1:0]  nxt
);
  logic carry;

  always_comb begin
    nxt   = ptr;
    carry = 1'b0;
    for (int j = MAXLOG - 1; j >= 0; j--) begin
      if (SZW'(j) < k) begin
        nxt[j] = ptr[j] ^ step[j] ^ carry;
        carry  = (ptr[j] & step[j]) | (carry & (ptr[j] ^ step[j]));
      end
    end
  end
endmodule

// File: rtl/agu_chan.sv
module agu_chan
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int SZW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [2:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_hit,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0]  ptr_q, step_q, base_q, len_q;
  amode_t         mode_q;
  logic [SZW-1:0] size_q;
  logic [SZW-1:0] k_eff;
  logic [AW-1:0]  ring_nxt, rev_nxt, nxt, ptr_d;

  always_comb begin
    if (size_q == '0)                 k_eff = SZW'(1);
    else if (size_q > SZW'(MAXLOG))   k_eff = SZW'(MAXLOG);
    else                              k_eff = size_q;
  end

  agu_ring_step #(.AW(AW)) u_ring (
    .ptr(ptr_q), .step(step_q), .base(base_q), .len(len_q), .nxt(ring_nxt)
  );

  agu_revcarry #(.AW(AW), .MAXLOG(MAXLOG), .SZW(SZW)) u_rev (
    .ptr(ptr_q), .step(step_q), .k(k_eff), .nxt(rev_nxt)
  );

  always_comb begin
    unique case (mode_q)
      AM_HOLD:     nxt = ptr_q;
      AM_LINEAR:   nxt = ptr_q + step_q;
      AM_RING:     nxt = ring_nxt;
      AM_REVCARRY: nxt = rev_nxt;
      default:     nxt = ptr_q;
    endcase
  end

  always_comb begin
    ptr_d = ptr_q;
    if (acc_hit) ptr_d = nxt;
    if (wr_hit && wr_field == FLD_PTR) ptr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= '0;
      base_q <= '0;
      len_q  <= '0;
      mode_q <= AM_HOLD;
      size_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (wr_hit) begin
        unique case (wr_field)
          FLD_STEP: step_q <= wr_data;
          FLD_BASE: base_q <= wr_data;
          FLD_LEN:  len_q  <= wr_data;
          FLD_MODE: mode_q <= amode_t'(wr_data[1:0]);
          FLD_SIZE: size_q <= wr_data[SZW-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter  int NCH    = 4,
  parameter  int AW     = 16,
  parameter  int MAXLOG = 10,
  localparam int CSW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SZW    = $clog2(MAXLOG + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CSW-1:0] wr_sel,
  input  logic [2:0]     wr_field,
  input  logic [AW-1:0]  wr_data,
  input  logic           acc_valid,
  input  logic [CSW-1:0] acc_sel,
  output logic [AW-1:0]  addr_out,
  output logic           addr_vld
);
  logic [NCH-1:0][AW-1:0] ptr_all;
  logic [AW-1:0]          addr_q;
  logic                   vld_q;

  generate
    if (AW < MAXLOG) begin : g_bad_width
      initial $error("AW must be at least MAXLOG");
    end
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic wr_hit, acc_hit;
      assign wr_hit  = wr_en && (wr_sel == CSW'(c));
      assign acc_hit = acc_valid && (acc_sel == CSW'(c));
      agu_chan #(.AW(AW), .MAXLOG(MAXLOG), .SZW(SZW)) u_chan (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_field(wr_field),
        .wr_data(wr_data), .acc_hit(acc_hit), .ptr(ptr_all[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= acc_valid;
      if (acc_valid) addr_q <= ptr_all[acc_sel];
    end
  end

  assign addr_out = addr_q;
  assign addr_vld = vld_q;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CSW = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [CSW-1:0]         wr_sel,
  input logic [2:0]             wr_field,
  input logic [AW-1:0]          wr_data,
  input logic                   acc_valid,
  input logic [CSW-1:0]         acc_sel,
  input logic [AW-1:0]          addr_out,
  input logic                   addr_vld,
  input logic [NCH-1:0][AW-1:0] ptr_all
);
  logic [AW-1:0] sel_ptr;
  assign sel_ptr = ptr_all[acc_sel];

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_vld); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !addr_vld); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(addr_out)); // R8
  AST_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_out == $past(sel_ptr)); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_IDLE_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(acc_valid && acc_sel == CSW'(c)) && !(wr_en && wr_sel == CSW'(c) && wr_field == 3'd0))
      |=> $stable(ptr_all[c])); // R7
    AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == CSW'(c) && wr_field == 3'd0) |=> ptr_all[c] == $past(wr_data)); // R9
  end
endmodule

bind agu_top agu_chk #(.NCH(NCH), .AW(AW), .CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_field(wr_field),
  .wr_data(wr_data), .acc_valid(acc_valid), .acc_sel(acc_sel),
  .addr_out(addr_out), .addr_vld(addr_vld), .ptr_all(ptr_all)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [2:0]    wr_field = '0;
  logic [AW-1:0] wr_data = '0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_sel = '0;
  logic [AW-1:0] addr_out;
  logic          addr_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ptr[NCH], m_step[NCH], m_base[NCH], m_len[NCH], m_mode[NCH], m_size[NCH];
  int exp_addr = 0;

  always #10 clk = ~clk;

  agu_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_field(wr_field),
    .wr_data(wr_data), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  function automatic int f_rev(int v, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (((v >> i) & 1) != 0) r |= (1 << (k - 1 - i));
    return r;
  endfunction

  function automatic int f_next(int c);
    int p = m_ptr[c];
    int st, s, k, mask, lo;
    case (m_mode[c])
      1: return (p + m_step[c]) & 32'hFFFF;
      2: begin
        st = (m_step[c] >= 32768) ? m_step[c] - 65536 : m_step[c];
        s = p + st;
        if (st >= 0) begin
          if (s >= m_base[c] + m_len[c]) s -= m_len[c];
        end else if (s < m_base[c]) s += m_len[c];
        return s & 32'hFFFF;
      end
      3: begin
        k = (m_size[c] == 0) ? 1 : (m_size[c] > 10 ? 10 : m_size[c]);
        mask = (1 << k) - 1;
        lo = f_rev((f_rev(p & mask, k) + f_rev(m_step[c] & mask, k)) & mask, k);
        return (p & ~mask) | lo;
      end
      default: return p;
    endcase
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(bit we, int wsel, int wfld, int wdat, bit av, int asel, string req);
    wr_en = we; wr_sel = 2'(wsel); wr_field = 3'(wfld); wr_data = 16'(wdat);
    acc_valid = av; acc_sel = 2'(asel);
    if (av) begin
      exp_addr = m_ptr[asel];
      m_ptr[asel] = f_next(asel);
    end
    if (we) begin
      case (wfld)
        0: m_ptr[wsel]  = wdat & 32'hFFFF;
        1: m_step[wsel] = wdat & 32'hFFFF;
        2: m_base[wsel] = wdat & 32'hFFFF;
        3: m_len[wsel]  = wdat & 32'hFFFF;
        4: m_mode[wsel] = wdat & 3;
        5: m_size[wsel] = wdat & 15;
        default: ;
      endcase
    end
    @(negedge clk);
    check("R8", int'(addr_vld), int'(av));
    check(req, int'(addr_out), exp_addr);
  endtask

  task automatic wr(int c, int f, int d);
    cyc(1'b1, c, f, d, 1'b0, 0, "R10");
  endtask

  task automatic acc(int c, string req);
    cyc(1'b0, 0, 0, 0, 1'b1, c, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    string tags[4] = '{"R2", "R3", "R4", "R6"};
    for (int c = 0; c < NCH; c++) begin
      m_ptr[c] = 0; m_step[c] = 0; m_base[c] = 0; m_len[c] = 0; m_mode[c] = 0; m_size[c] = 0;
    end
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    check("R1", int'(addr_vld), 0);
    check("R1", int'(addr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(0, "R1");
    acc(0, "R2");
    wr(0, 0, 77);
    acc(0, "R9");
    acc(0, "R2");
    // R3 linear stepping and modulo wrap
    wr(1, 0, 100); wr(1, 1, 3); wr(1, 4, 1);
    acc(1, "R3"); acc(1, "R3"); acc(1, "R3");
    wr(1, 0, 16'hFFFE);
    acc(1, "R3"); acc(1, "R3");
    // R4 ring with exact-boundary wrap
    wr(2, 2, 200); wr(2, 3, 5); wr(2, 1, 2); wr(2, 0, 200); wr(2, 4, 2);
    for (int i = 0; i < 7; i++) acc(2, "R4");
    // R5 ring with negative step
    wr(2, 1, 16'hFFFE); wr(2, 0, 200);
    for (int i = 0; i < 6; i++) acc(2, "R5");
    // R7 other channels untouched
    acc(1, "R7"); acc(0, "R7");
    // R6 reversed-carry walk of 8 points
    wr(3, 0, 16'h40); wr(3, 1, 4); wr(3, 5, 3); wr(3, 4, 3);
    for (int i = 0; i < 9; i++) acc(3, "R6");
    wr(3, 5, 0); wr(3, 1, 1);
    acc(3, "R6"); acc(3, "R6"); acc(3, "R6");
    wr(3, 5, 15); wr(3, 1, 16'h200);
    acc(3, "R6"); acc(3, "R6");
    // R9 pointer write collides with strobe on the same channel
    cyc(1'b1, 1, 0, 500, 1'b1, 1, "R9");
    acc(1, "R9");
    // R10 unused field codes ignored, non-pointer write uses old value
    wr(1, 6, 16'h1234); wr(1, 7, 16'h4321);
    acc(1, "R10"); acc(1, "R10");
    cyc(1'b1, 1, 1, 10, 1'b1, 1, "R10");
    acc(1, "R10"); acc(1, "R10");
    cyc(1'b0, 0, 0, 0, 1'b0, 0, "R8");
    cyc(1'b0, 0, 0, 0, 1'b0, 0, "R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 4) == 0;
      int wc = $urandom % NCH;
      int wf = $urandom % 8;
      int wd = $urandom & 32'hFFFF;
      bit av = ($urandom % 4) != 0;
      int ac = $urandom % NCH;
      if (wf == 3) wd = 1 + ($urandom % 64);
      if (wf == 1) wd = (($urandom % 9) - 4) & 32'hFFFF;
      if (wf == 0) wd = m_base[wc] + ($urandom % 64);
      cyc(we, wc, wf, wd, av, ac, av ? tags[m_mode[ac]] : "R8");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule